// File: doc/BRIEF.md
# MOESI Cache-Line Coherence Controller

This block keeps the coherence state of a small set of cache lines under a five-state protocol: Invalid, Shared, Exclusive, Owned and Modified. A core-side agent presents local events against a line index. The events are load miss, instruction-fetch miss, store/atomic access, prefetch-for-write and victimisation. The controller decides from the line's current state whether a bus request is needed. If one is, it raises a one-cycle request and records it as pending. It commits the final state only when the system's reply arrives.

From the other side, the system presents snoops against a line index. The controller moves the line to its new state at once and acknowledges one cycle later. The acknowledgement is marked dirty when the line held data newer than memory. When the snoop needs data, the controller signals the start of a copyback transfer and stays busy until the system closes it with a copyback-done reply. A snoop aimed at a line with a request in flight is held off until that request completes. A reply that matches no pending request is rejected: it raises an error pulse and leaves the line state untouched. The data array, memory and system controller are outside the block.

Top module: `moesi_line_ctl`

## Requirements
- R1: A load miss (op code 0) to an Invalid line issues a read-shared request (kind 1). A fill-unshared reply (kind 1) then leaves the line Exclusive, and a fill-shared reply (kind 2) leaves it Shared.
- R2: An instruction-fetch miss (op code 1) to an Invalid line issues a read-shared-always request (kind 2). Only a fill-shared reply completes it, and the line ends Shared.
- R3: A store/atomic (op code 2) or prefetch-for-write (op code 3) to an Invalid line issues a read-to-own request (kind 3). A fill-unshared reply completes it and leaves the line Modified.
- R4: A store/atomic to an Exclusive line makes it Modified in the following cycle, with no bus request.
- R5: A store/atomic to a Shared or Owned line issues a read-to-own request. The line keeps its state until an ownership-ack reply (kind 3), which makes it Modified.
- R6: A copyback-share snoop (snoop code 0) moves Exclusive to Shared and Modified to Owned, and leaves Shared and Owned unchanged. A copyback-share-with-memory-update snoop (snoop code 1) moves Exclusive, Modified or Owned to Shared. In both cases the acknowledgement is dirty exactly when the line was Modified or Owned.
- R7: A copyback-invalidate snoop (snoop code 2) moves a valid line to Invalid and is followed by a copyback transfer. A plain invalidate snoop (snoop code 3) moves the line to Invalid with an acknowledgement only and no copyback.
- R8: The snoop acknowledgement appears one cycle after the snoop is accepted. If a copyback is required, its start pulse follows one cycle later. No further snoop is accepted until a copyback-done reply (kind 6) arrives for that line.
- R9: Victimising (op code 4) a Modified or Owned line issues a writeback request (kind 4). The line keeps its state until either a writeback-ack (kind 4) or a writeback-cancel (kind 5) arrives, and both end in Invalid.
- R10: Victimising an Exclusive or Shared line makes it Invalid in the following cycle, with no bus request.
- R11: While a line has a request outstanding, local events to it are refused (local-ready low). Snoops to it are held (snoop-ready low) until the reply completes the request.
- R12: A reply that does not complete the line's pending request produces a one-cycle error pulse and leaves the line state unchanged. This covers a reply of the wrong kind, a reply with nothing pending, and a copyback-done with no copyback open.
- R13: After reset every line reads Invalid (state code 0; S=1, E=2, O=3, M=4). No request, acknowledgement, copyback or error is active, and both ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_valid | input | 1 | Local event present |
| loc_op | input | 3 | Local event code |
| loc_idx | input | IW | Line index of local event |
| loc_ready | output | 1 | Local event will be taken this cycle |
| req_valid | output | 1 | Bus request pulse |
| req_kind | output | 3 | Bus request kind |
| req_idx | output | IW | Line index of bus request |
| rsp_valid | input | 1 | System reply present |
| rsp_kind | input | 3 | System reply kind |
| rsp_idx | input | IW | Line index of reply |
| snp_valid | input | 1 | Snoop present |
| snp_kind | input | 2 | Snoop code |
| snp_idx | input | IW | Line index of snoop |
| snp_ready | output | 1 | Snoop will be taken this cycle |
| sack_valid | output | 1 | Snoop acknowledgement pulse |
| sack_dirty | output | 1 | Acknowledgement is the dirty form |
| cb_valid | output | 1 | Copyback transfer start pulse |
| cb_idx | output | IW | Line index of the open snoop/copyback |
| err | output | 1 | Illegal reply pulse |
| look_idx | input | IW | Line index to read state of |
| look_state | output | 3 | State code of the line at look_idx |

## Verification
The hardest situation to reach is a snoop colliding with a line that still waits for its fill. In that case the snoop must stay parked, the fill must land first, and only then may the snoop act on the newly filled state. The stimulus issues a load miss, then holds a snoop to the same index across several cycles while checking both ready outputs. It delivers the fill under the held snoop and confirms that the acknowledgement reflects the post-fill state. A second hard corner is an Owned line. Reaching it takes a chain of upgrade, ownership ack and copyback-share, which the bench builds before it victimises the line and answers with a writeback-cancel.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

    typedef enum logic [2:0] {
        ST_I = 3'd0,
        ST_S = 3'd1,
        ST_E = 3'd2,
        ST_O = 3'd3,
        ST_M = 3'd4
    } line_st_e;

    typedef enum logic [2:0] {
        OP_LOAD   = 3'd0,
        OP_IFETCH = 3'd1,
        OP_STORE  = 3'd2,
        OP_PREF   = 3'd3,
        OP_VICT   = 3'd4
    } loc_op_e;

    typedef enum logic [2:0] {
        RQ_NONE = 3'd0,
        RQ_RDS  = 3'd1,
        RQ_RDSA = 3'd2,
        RQ_RDO  = 3'd3,
        RQ_WRB  = 3'd4
    } bus_req_e;

    typedef enum logic [2:0] {
        RP_NONE    = 3'd0,
        RP_FILL_U  = 3'd1,
        RP_FILL_S  = 3'd2,
        RP_OWN     = 3'd3,
        RP_WB_ACK  = 3'd4,
        RP_WB_CAN  = 3'd5,
        RP_CB_DONE = 3'd6
    } reply_e;

    typedef enum logic [1:0] {
        SN_CPB     = 2'd0,
        SN_CPB_MEM = 2'd1,
        SN_CPI     = 2'd2,
        SN_INV     = 2'd3
    } snoop_e;

    typedef enum logic [2:0] {
        PK_RDS     = 3'd0,
        PK_RDSA    = 3'd1,
        PK_FILLOWN = 3'd2,
        PK_UPGRADE = 3'd3,
        PK_WB      = 3'd4
    } pend_kind_e;

    typedef struct packed {
        logic       valid;
        pend_kind_e kind;
    } pend_t;

    typedef struct packed {
        logic       st_we;
        line_st_e   st_nxt;
        logic       issue;
        bus_req_e   req;
        pend_kind_e pk;
    } loc_dec_t;

    typedef enum logic [1:0] {
        SE_IDLE = 2'd0,
        SE_ACK  = 2'd1,
        SE_XFER = 2'd2,
        SE_WAIT = 2'd3
    } snp_fsm_e;

    function automatic logic st_dirty(line_st_e s);
        return (s == ST_M) || (s == ST_O);
    endfunction

    function automatic line_st_e snoop_next(snoop_e k, line_st_e s);
        line_st_e n;
        n = s;
        case (k)
            SN_CPB:     if (s == ST_E) n = ST_S; else if (s == ST_M) n = ST_O;
            SN_CPB_MEM: if (s != ST_I) n = ST_S;
            default:    n = ST_I;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/moesi_state_array.sv
module moesi_state_array
    import moesi_pkg::*;
#(
    parameter int NLINES = 8,
    localparam int IW = $clog2(NLINES)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    a_we,
    input  logic [IW-1:0]           a_idx,
    input  line_st_e                a_st,
    input  logic                    a_pset,
    input  pend_kind_e              a_pk,
    input  logic                    b_we,
    input  logic [IW-1:0]           b_idx,
    input  line_st_e                b_st,
    input  logic                    b_pclr,
    input  logic                    c_we,
    input  logic [IW-1:0]           c_idx,
    input  line_st_e                c_st,
    output line_st_e [NLINES-1:0]   st_q,
    output pend_t    [NLINES-1:0]   pend_q
);

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        line_st_e line_st;
        pend_t    line_pend;
        logic     hit_a, hit_b, hit_c;

        assign hit_a = (a_idx == IW'(g));
        assign hit_b = (b_idx == IW'(g));
        assign hit_c = (c_idx == IW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                line_st   <= ST_I;
                line_pend <= '0;
            end else begin
                if (hit_a && a_we)      line_st <= a_st;
                else if (hit_b && b_we) line_st <= b_st;
                else if (hit_c && c_we) line_st <= c_st;

                if (hit_a && a_pset) begin
                    line_pend.valid <= 1'b1;
                    line_pend.kind  <= a_pk;
                end else if (hit_b && b_pclr) begin
                    line_pend.valid <= 1'b0;
                end
            end
        end

        assign st_q[g]   = line_st;
        assign pend_q[g] = line_pend;

        // R11: local, reply and snoop writers never collide on one line
        p_single_writer_r11: assert property (@(posedge clk) disable iff (rst)
            $countones({hit_a && a_we, hit_b && b_we, hit_c && c_we}) <= 1);

        // R11: a new request is never recorded over an outstanding one
        p_no_double_pend_r11: assert property (@(posedge clk) disable iff (rst)
            (hit_a && a_pset) |-> !line_pend.valid);
    end

endmodule

// File: rtl/moesi_local_dec.sv
module moesi_local_dec
    import moesi_pkg::*;
(
    input  loc_op_e  op,
    input  line_st_e st,
    output loc_dec_t dec
);

    always_comb begin
        dec = '0;
        case (op)
            OP_LOAD, OP_IFETCH: begin
                if (st == ST_I) begin
                    dec.issue = 1'b1;
                    dec.req   = (op == OP_LOAD) ? RQ_RDS : RQ_RDSA;
                    dec.pk    = (op == OP_LOAD) ? PK_RDS : PK_RDSA;
                end
            end
            OP_STORE, OP_PREF: begin
                case (st)
                    ST_I: begin
                        dec.issue = 1'b1;
                        dec.req   = RQ_RDO;
                        dec.pk    = PK_FILLOWN;
                    end
                    ST_E: begin
                        dec.st_we  = 1'b1;
                        dec.st_nxt = ST_M;
                    end
                    ST_S, ST_O: begin
                        dec.issue = 1'b1;
                        dec.req   = RQ_RDO;
                        dec.pk    = PK_UPGRADE;
                    end
                    default: ;
                endcase
            end
            OP_VICT: begin
                if (st_dirty(st)) begin
                    dec.issue = 1'b1;
                    dec.req   = RQ_WRB;
                    dec.pk    = PK_WB;
                end else if (st != ST_I) begin
                    dec.st_we  = 1'b1;
                    dec.st_nxt = ST_I;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/moesi_reply_chk.sv
module moesi_reply_chk
    import moesi_pkg::*;
(
    input  pend_t    pend,
    input  reply_e   kind,
    input  logic     cb_match,
    output logic     ok,
    output logic     st_we,
    output line_st_e st_nxt,
    output logic     pclr
);

    always_comb begin
        ok     = 1'b0;
        st_nxt = ST_I;
        case (kind)
            RP_FILL_U: begin
                if (pend.valid && pend.kind == PK_RDS)     begin ok = 1'b1; st_nxt = ST_E; end
                if (pend.valid && pend.kind == PK_FILLOWN) begin ok = 1'b1; st_nxt = ST_M; end
            end
            RP_FILL_S: begin
                if (pend.valid && (pend.kind == PK_RDS || pend.kind == PK_RDSA)) begin
                    ok     = 1'b1;
                    st_nxt = ST_S;
                end
            end
            RP_OWN: begin
                if (pend.valid && pend.kind == PK_UPGRADE) begin ok = 1'b1; st_nxt = ST_M; end
            end
            RP_WB_ACK, RP_WB_CAN: begin
                if (pend.valid && pend.kind == PK_WB) begin ok = 1'b1; st_nxt = ST_I; end
            end
            RP_CB_DONE: ok = cb_match;
            default: ;
        endcase
        st_we = ok && (kind != RP_CB_DONE);
        pclr  = st_we;
    end

endmodule

// File: rtl/moesi_snoop_eng.sv
module moesi_snoop_eng
    import moesi_pkg::*;
#(
    parameter int NLINES = 8,
    localparam int IW = $clog2(NLINES)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           fire,
    input  snoop_e         kind,
    input  line_st_e       cur,
    input  logic [IW-1:0]  idx,
    input  logic           cb_done,
    output logic           busy,
    output logic           cb_open,
    output logic [IW-1:0]  open_idx,
    output logic           sack_valid,
    output logic           sack_dirty,
    output logic           cb_valid,
    output logic           st_we,
    output line_st_e       st_nxt
);

    snp_fsm_e fsm;
    logic     need_cb, cb_q, dirty_q;

    assign need_cb = (kind != SN_INV) && (cur != ST_I);
    assign st_we   = fire;
    assign st_nxt  = snoop_next(kind, cur);

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm      <= SE_IDLE;
            cb_q     <= 1'b0;
            dirty_q  <= 1'b0;
            open_idx <= '0;
        end else begin
            case (fsm)
                SE_IDLE: if (fire) begin
                    fsm      <= SE_ACK;
                    cb_q     <= need_cb;
                    dirty_q  <= st_dirty(cur);
                    open_idx <= idx;
                end
                SE_ACK:  fsm <= cb_q ? SE_XFER : SE_IDLE;
                SE_XFER: fsm <= cb_done ? SE_IDLE : SE_WAIT;
                SE_WAIT: if (cb_done) fsm <= SE_IDLE;
                default: fsm <= SE_IDLE;
            endcase
        end
    end

    assign busy       = (fsm != SE_IDLE);
    assign cb_open    = (fsm == SE_XFER) || (fsm == SE_WAIT);
    assign sack_valid = (fsm == SE_ACK);
    assign sack_dirty = sack_valid && dirty_q;
    assign cb_valid   = (fsm == SE_XFER);

    // R7: an acknowledgement without copyback is not followed by a transfer
    p_inv_no_copyback_r7: assert property (@(posedge clk) disable iff (rst)
        (sack_valid && !cb_q) |=> !cb_valid);

    // R8: the copyback start comes exactly one cycle after the acknowledgement
    p_cb_after_ack_r8: assert property (@(posedge clk) disable iff (rst)
        cb_valid |-> $past(sack_valid));

endmodule

// File: rtl/moesi_line_ctl.sv
module moesi_line_ctl
    import moesi_pkg::*;
#(
    parameter int NLINES = 8,
    localparam int IW = $clog2(NLINES)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           loc_valid,
    input  logic [2:0]     loc_op,
    input  logic [IW-1:0]  loc_idx,
    output logic           loc_ready,
    output logic           req_valid,
    output logic [2:0]     req_kind,
    output logic [IW-1:0]  req_idx,
    input  logic           rsp_valid,
    input  logic [2:0]     rsp_kind,
    input  logic [IW-1:0]  rsp_idx,
    input  logic           snp_valid,
    input  logic [1:0]     snp_kind,
    input  logic [IW-1:0]  snp_idx,
    output logic           snp_ready,
    output logic           sack_valid,
    output logic           sack_dirty,
    output logic           cb_valid,
    output logic [IW-1:0]  cb_idx,
    output logic           err,
    input  logic [IW-1:0]  look_idx,
    output logic [2:0]     look_state
);

    line_st_e [NLINES-1:0] st_q;
    pend_t    [NLINES-1:0] pend_q;

    loc_dec_t dec;
    logic     loc_fire, snp_fire, snp_busy, cb_open;
    logic     rsp_ok, rsp_we, rsp_pclr, cb_done;
    line_st_e rsp_st, snp_st;
    logic     snp_we;
    reply_e   rsp_k;

    assign rsp_k = reply_e'(rsp_kind);

    assign snp_ready = !snp_busy && !pend_q[snp_idx].valid;
    assign snp_fire  = snp_valid && snp_ready;

    assign loc_ready = !pend_q[loc_idx].valid
                    && !(snp_busy && cb_idx == loc_idx)
                    && !(snp_valid && snp_idx == loc_idx);
    assign loc_fire  = loc_valid && loc_ready;

    moesi_local_dec u_dec (
        .op  (loc_op_e'(loc_op)),
        .st  (st_q[loc_idx]),
        .dec (dec)
    );

    moesi_reply_chk u_chk (
        .pend     (pend_q[rsp_idx]),
        .kind     (rsp_k),
        .cb_match (cb_open && cb_idx == rsp_idx),
        .ok       (rsp_ok),
        .st_we    (rsp_we),
        .st_nxt   (rsp_st),
        .pclr     (rsp_pclr)
    );

    assign cb_done = rsp_valid && rsp_ok && (rsp_k == RP_CB_DONE);

    moesi_snoop_eng #(.NLINES(NLINES)) u_snp (
        .clk        (clk),
        .rst        (rst),
        .fire       (snp_fire),
        .kind       (snoop_e'(snp_kind)),
        .cur        (st_q[snp_idx]),
        .idx        (snp_idx),
        .cb_done    (cb_done),
        .busy       (snp_busy),
        .cb_open    (cb_open),
        .open_idx   (cb_idx),
        .sack_valid (sack_valid),
        .sack_dirty (sack_dirty),
        .cb_valid   (cb_valid),
        .st_we      (snp_we),
        .st_nxt     (snp_st)
    );

    moesi_state_array #(.NLINES(NLINES)) u_arr (
        .clk    (clk),
        .rst    (rst),
        .a_we   (loc_fire && dec.st_we),
        .a_idx  (loc_idx),
        .a_st   (dec.st_nxt),
        .a_pset (loc_fire && dec.issue),
        .a_pk   (dec.pk),
        .b_we   (rsp_valid && rsp_we),
        .b_idx  (rsp_idx),
        .b_st   (rsp_st),
        .b_pclr (rsp_valid && rsp_pclr),
        .c_we   (snp_we),
        .c_idx  (snp_idx),
        .c_st   (snp_st),
        .st_q   (st_q),
        .pend_q (pend_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid <= 1'b0;
            req_kind  <= 3'd0;
            req_idx   <= '0;
            err       <= 1'b0;
        end else begin
            req_valid <= loc_fire && dec.issue;
            req_kind  <= (loc_fire && dec.issue) ? 3'(dec.req) : 3'd0;
            req_idx   <= loc_idx;
            err       <= rsp_valid && !rsp_ok;
        end
    end

    assign look_state = 3'(st_q[look_idx]);

    // R4: a store to an Exclusive line upgrades silently
    p_silent_upgrade_r4: assert property (@(posedge clk) disable iff (rst)
        (loc_fire && loc_op == 3'(OP_STORE) && st_q[loc_idx] == ST_E)
        |=> (!req_valid && st_q[$past(loc_idx)] == ST_M));

    // R11: every issued request has a pending record behind it
    p_req_pending_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> pend_q[req_idx].valid);

    // R12: a rejected reply leaves the addressed line as it was
    p_bad_reply_keeps_state_r12: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ok && !(loc_fire && loc_idx == rsp_idx)
                             && !(snp_fire && snp_idx == rsp_idx))
        |=> st_q[$past(rsp_idx)] == $past(st_q[rsp_idx]));

    // R9: writeback ack or cancel always ends Invalid
    p_wb_ends_invalid_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ok && (rsp_k == RP_WB_ACK || rsp_k == RP_WB_CAN))
        |=> st_q[$past(rsp_idx)] == ST_I);

endmodule

// File: tb/moesi_line_ctl_test.sv
module moesi_line_ctl_test;

    localparam int NL = 8;
    localparam int IW = $clog2(NL);

    localparam logic [2:0] S_I = 3'd0, S_S = 3'd1, S_E = 3'd2, S_O = 3'd3, S_M = 3'd4;
    localparam logic [2:0] O_LD = 3'd0, O_IF = 3'd1, O_ST = 3'd2, O_PF = 3'd3, O_VI = 3'd4;
    localparam logic [2:0] Q_RDS = 3'd1, Q_RDSA = 3'd2, Q_RDO = 3'd3, Q_WRB = 3'd4;
    localparam logic [2:0] A_FU = 3'd1, A_FS = 3'd2, A_OWN = 3'd3, A_WBA = 3'd4, A_WBC = 3'd5, A_CBD = 3'd6;
    localparam logic [1:0] N_CPB = 2'd0, N_CPBM = 2'd1, N_CPI = 2'd2, N_INV = 2'd3;

    logic clk = 1'b0, rst = 1'b1;
    logic loc_valid = 0, rsp_valid = 0, snp_valid = 0;
    logic [2:0] loc_op = 0, rsp_kind = 0;
    logic [1:0] snp_kind = 0;
    logic [IW-1:0] loc_idx = 0, rsp_idx = 0, snp_idx = 0, look_idx = 0;
    logic loc_ready, req_valid, snp_ready, sack_valid, sack_dirty, cb_valid, err;
    logic [2:0] req_kind, look_state;
    logic [IW-1:0] req_idx, cb_idx;

    int tests = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    moesi_line_ctl #(.NLINES(NL)) uut (
        .clk(clk), .rst(rst),
        .loc_valid(loc_valid), .loc_op(loc_op), .loc_idx(loc_idx), .loc_ready(loc_ready),
        .req_valid(req_valid), .req_kind(req_kind), .req_idx(req_idx),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_idx(rsp_idx),
        .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_idx(snp_idx), .snp_ready(snp_ready),
        .sack_valid(sack_valid), .sack_dirty(sack_dirty), .cb_valid(cb_valid), .cb_idx(cb_idx),
        .err(err), .look_idx(look_idx), .look_state(look_state)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_state(string tag, int idx, logic [2:0] exp);
        look_idx = IW'(idx);
        #1;
        check(tag, 32'(look_state), 32'(exp));
    endtask

    // local event, then check the request it produced
    task automatic local_ev(string tag, logic [2:0] op, int idx, logic exp_req, logic [2:0] exp_kind);
        @(negedge clk);
        loc_valid = 1; loc_op = op; loc_idx = IW'(idx);
        @(negedge clk);
        loc_valid = 0;
        check({tag, " req_valid"}, 32'(req_valid), 32'(exp_req));
        if (exp_req) begin
            check({tag, " req_kind"}, 32'(req_kind), 32'(exp_kind));
            check({tag, " req_idx"}, 32'(req_idx), 32'(idx));
        end
    endtask

    task automatic reply(string tag, logic [2:0] kind, int idx, logic exp_err);
        @(negedge clk);
        rsp_valid = 1; rsp_kind = kind; rsp_idx = IW'(idx);
        @(negedge clk);
        rsp_valid = 0;
        check({tag, " err"}, 32'(err), 32'(exp_err));
    endtask

    task automatic snoop(string tag, logic [1:0] kind, int idx, logic exp_dirty, logic exp_cb);
        @(negedge clk);
        snp_valid = 1; snp_kind = kind; snp_idx = IW'(idx);
        #1 check({tag, " snp_ready"}, 32'(snp_ready), 1);
        @(negedge clk);
        snp_valid = 0;
        check({tag, " sack_valid"}, 32'(sack_valid), 1);
        check({tag, " sack_dirty"}, 32'(sack_dirty), 32'(exp_dirty));
        @(negedge clk);
        check({tag, " cb_valid"}, 32'(cb_valid), 32'(exp_cb));
        if (exp_cb) begin
            check({tag, " busy during copyback"}, 32'(snp_ready), 0);
            rsp_valid = 1; rsp_kind = A_CBD; rsp_idx = IW'(idx);
            @(negedge clk);
            rsp_valid = 0;
            check({tag, " copyback done err"}, 32'(err), 0);
            #1 check({tag, " ready after done"}, 32'(snp_ready), 1);
        end
    endtask

    task automatic t_reset();
        for (int i = 0; i < NL; i++) chk_state("R13 reset state", i, S_I);
        check("R13 req idle", 32'(req_valid), 0);
        check("R13 sack idle", 32'(sack_valid), 0);
        check("R13 cb idle", 32'(cb_valid), 0);
        check("R13 err idle", 32'(err), 0);
        check("R13 loc_ready", 32'(loc_ready), 1);
        check("R13 snp_ready", 32'(snp_ready), 1);
    endtask

    task automatic t_load();
        local_ev("R1 load miss", O_LD, 0, 1, Q_RDS);
        chk_state("R1 still I before fill", 0, S_I);
        reply("R1 fill unshared", A_FU, 0, 0);
        chk_state("R1 ends E", 0, S_E);
        local_ev("R1 load miss b", O_LD, 1, 1, Q_RDS);
        reply("R1 fill shared", A_FS, 1, 0);
        chk_state("R1 ends S", 1, S_S);
        local_ev("R1 load hit no req", O_LD, 1, 0, 0);
    endtask

    task automatic t_ifetch();
        local_ev("R2 ifetch miss", O_IF, 2, 1, Q_RDSA);
        reply("R2 fill shared", A_FS, 2, 0);
        chk_state("R2 ends S", 2, S_S);
        local_ev("R2 ifetch miss b", O_IF, 3, 1, Q_RDSA);
        reply("R12 unshared fill to ifetch", A_FU, 3, 1);
        chk_state("R12 state kept", 3, S_I);
        loc_idx = 3; #1 check("R11 pending refuses local", 32'(loc_ready), 0);
        reply("R2 fill shared b", A_FS, 3, 0);
        chk_state("R2 ends S b", 3, S_S);
    endtask

    task automatic t_store_miss();
        local_ev("R3 store miss", O_ST, 4, 1, Q_RDO);
        reply("R3 fill", A_FU, 4, 0);
        chk_state("R3 ends M", 4, S_M);
        local_ev("R3 prefetch miss", O_PF, 5, 1, Q_RDO);
        reply("R3 fill b", A_FU, 5, 0);
        chk_state("R3 prefetch ends M", 5, S_M);
    endtask

    task automatic t_silent();
        local_ev("R4 store to E", O_ST, 0, 0, 0);
        chk_state("R4 now M", 0, S_M);
    endtask

    task automatic t_upgrade();
        local_ev("R5 store to S", O_ST, 1, 1, Q_RDO);
        chk_state("R5 still S", 1, S_S);
        reply("R12 fill to upgrade", A_FU, 1, 1);
        chk_state("R12 upgrade state kept", 1, S_S);
        reply("R5 ownership ack", A_OWN, 1, 0);
        chk_state("R5 ends M", 1, S_M);
    endtask

    task automatic t_cpb();
        snoop("R6 cpb on M", N_CPB, 0, 1, 1);
        chk_state("R6 M to O", 0, S_O);
        snoop("R6 cpb on O", N_CPB, 0, 1, 1);
        chk_state("R6 O stays O", 0, S_O);
        snoop("R6 cpb-mem on O", N_CPBM, 0, 1, 1);
        chk_state("R6 O to S", 0, S_S);
        local_ev("R6 load for E", O_LD, 6, 1, Q_RDS);
        reply("R6 fill E", A_FU, 6, 0);
        snoop("R6 cpb on E", N_CPB, 6, 0, 1);
        chk_state("R6 E to S", 6, S_S);
        local_ev("R6 upgrade 6", O_ST, 6, 1, Q_RDO);
        reply("R6 own 6", A_OWN, 6, 0);
        snoop("R6 cpb-mem on M", N_CPBM, 6, 1, 1);
        chk_state("R6 M to S", 6, S_S);
    endtask

    task automatic t_cpi_inv();
        snoop("R7 cpi on M", N_CPI, 4, 1, 1);
        chk_state("R7 cpi to I", 4, S_I);
        snoop("R7 inv on M", N_INV, 5, 1, 0);
        chk_state("R7 inv to I", 5, S_I);
    endtask

    task automatic t_victim();
        local_ev("R9 victim M", O_VI, 1, 1, Q_WRB);
        chk_state("R9 M held", 1, S_M);
        reply("R9 wb ack", A_WBA, 1, 0);
        chk_state("R9 ack to I", 1, S_I);
        local_ev("R9 upgrade 2", O_ST, 2, 1, Q_RDO);
        reply("R9 own 2", A_OWN, 2, 0);
        snoop("R9 make O", N_CPB, 2, 1, 1);
        chk_state("R9 is O", 2, S_O);
        local_ev("R9 victim O", O_VI, 2, 1, Q_WRB);
        reply("R9 wb cancel", A_WBC, 2, 0);
        chk_state("R9 cancel to I", 2, S_I);
        local_ev("R10 victim S", O_VI, 0, 0, 0);
        chk_state("R10 S to I", 0, S_I);
        local_ev("R10 load for E", O_LD, 0, 1, Q_RDS);
        reply("R10 fill E", A_FU, 0, 0);
        local_ev("R10 victim E", O_VI, 0, 0, 0);
        chk_state("R10 E to I", 0, S_I);
    endtask

    task automatic t_held();
        local_ev("R11 load 7", O_LD, 7, 1, Q_RDS);
        @(negedge clk);
        snp_valid = 1; snp_kind = N_INV; snp_idx = 7;
        #1 check("R11 snoop held", 32'(snp_ready), 0);
        @(negedge clk);
        check("R11 snoop still held", 32'(snp_ready), 0);
        check("R11 no sack while held", 32'(sack_valid), 0);
        rsp_valid = 1; rsp_kind = A_FS; rsp_idx = 7;
        @(negedge clk);
        rsp_valid = 0;
        check("R11 fill under held snoop", 32'(err), 0);
        check("R11 snoop released", 32'(snp_ready), 1);
        @(negedge clk);
        snp_valid = 0;
        check("R11 sack after fill", 32'(sack_valid), 1);
        check("R11 sack clean for S", 32'(sack_dirty), 0);
        chk_state("R11 inv after fill", 7, S_I);
        @(negedge clk);
        check("R11 no copyback for inv", 32'(cb_valid), 0);
    endtask

    task automatic t_stray();
        reply("R12 cb done with none open", A_CBD, 3, 1);
        reply("R12 fill with nothing pending", A_FU, 0, 1);
        chk_state("R12 I kept", 0, S_I);
        reply("R12 own ack with nothing pending", A_OWN, 3, 1);
        chk_state("R12 S kept", 3, S_S);
        reply("R12 wb ack with nothing pending", A_WBA, 3, 1);
        chk_state("R12 S kept b", 3, S_S);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_load();
        t_ifetch();
        t_store_miss();
        t_silent();
        t_upgrade();
        t_cpb();
        t_cpi_inv();
        t_victim();
        t_held();
        t_stray();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule